// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor through its clock-stopping power states. It has four states: RUN (normal operation), STOP_GRANT (execution halted, clocks still running), SLEEP (unit clocks stopped, PLL running) and DEEP_SLEEP (PLL stopped as well). Moves between the states are driven by level-sensitive request inputs and by a flag that reports whether the bus clock is present. From the current state the block drives a core clock enable, a PLL enable and a mask that stops snoops and interrupts from being recognized.

The transitions are named as follows:
- ENTER_SG: RUN to STOP_GRANT.
- EXIT_SG: STOP_GRANT to RUN.
- ENTER_SLP: STOP_GRANT to SLEEP.
- WAKE_SLP: SLEEP to STOP_GRANT.
- ENTER_DSLP: SLEEP to DEEP_SLEEP.
- EXIT_DSLP: DEEP_SLEEP to SLEEP.
- RESET: any state to RUN.

All request inputs are sampled on the rising clock edge. The state and the outputs decoded from it change one clock after the edge that sees the condition. The active-low reset is asynchronous.

Top module: `lp_state_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the state is RUN. The state encoding is RUN=0, STOP_GRANT=1, SLEEP=2, DEEP_SLEEP=3. In RUN the outputs are core_clk_en=1, pll_en=1 and evt_mask=0. Asserting reset in any state, DEEP_SLEEP included, returns the block to RUN.
- R2: In RUN, sg_req=1 causes ENTER_SG on the next edge. In STOP_GRANT the outputs are core_clk_en=1, pll_en=1 and evt_mask=0. In RUN, slp_req, dslp_req and the loss of bclk_ok have no effect.
- R3: In STOP_GRANT, slp_req=1 causes ENTER_SLP whatever the value of sg_req. With slp_req=0 and sg_req=0 the block takes EXIT_SG back to RUN.
- R4: In SLEEP the outputs are core_clk_en=0, pll_en=1 and evt_mask=1.
- R5: In SLEEP, slp_req=0 together with dslp_req=0 and bclk_ok=1 causes WAKE_SLP to STOP_GRANT. On that transition core_clk_en returns to 1.
- R6: In SLEEP, dslp_req=1 or bclk_ok=0 causes ENTER_DSLP. This takes priority over a release of slp_req in the same cycle.
- R7: In DEEP_SLEEP the outputs are core_clk_en=0, pll_en=0 and evt_mask=1.
- R8: In DEEP_SLEEP, dslp_req=0 with bclk_ok=1 causes EXIT_DSLP to SLEEP. Otherwise the block stays in DEEP_SLEEP.
- R9: In SLEEP and DEEP_SLEEP, changes on sg_req have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces RUN |
| sg_req | input | 1 | Stop-grant request (level) |
| slp_req | input | 1 | Sleep request (level) |
| dslp_req | input | 1 | Deep-sleep request (level) |
| bclk_ok | input | 1 | High while the bus clock is present |
| state_o | output | 2 | Current state encoding |
| core_clk_en | output | 1 | Enable for the internal unit clocks |
| pll_en | output | 1 | Enable for the PLL |
| evt_mask | output | 1 | Blocks recognition of snoops and interrupts |

## Verification
The bench raises the sleep, deep-sleep and bus-clock-loss conditions while in RUN. A controller that did not qualify them by state would leave RUN and stop the clocks. It releases the sleep request and raises the deep-sleep request in the same cycle, where wrong priority would wake the core instead of stopping the PLL. It drops the stop-grant request while the block is asleep, and an unguarded decode would jump straight to RUN. It also brings the bus clock back with and without the deep-sleep request still held, and resets from DEEP_SLEEP; a wrong exit condition or a reset that missed a state would show up in the state and enable outputs.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN   = 2'd0,
        ST_SG    = 2'd1,
        ST_SLEEP = 2'd2,
        ST_DEEP  = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic core_clk_en;
        logic pll_en;
        logic evt_mask;
    } lp_ctrl_t;
endpackage

// File: rtl/lp_next_state.sv
module lp_next_state
    import lp_pkg::*;
(
    input  lp_state_e cur_state,
    input  logic      sg_req,
    input  logic      slp_req,
    input  logic      dslp_req,
    input  logic      bclk_ok,
    output lp_state_e nxt_state
);
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_RUN: begin
                if (sg_req) nxt_state = ST_SG;                    // ENTER_SG
            end
            ST_SG: begin
                if (slp_req)      nxt_state = ST_SLEEP;           // ENTER_SLP
                else if (!sg_req) nxt_state = ST_RUN;             // EXIT_SG
            end
            ST_SLEEP: begin
                if (dslp_req || !bclk_ok) nxt_state = ST_DEEP;    // ENTER_DSLP
                else if (!slp_req)        nxt_state = ST_SG;      // WAKE_SLP
            end
            ST_DEEP: begin
                if (!dslp_req && bclk_ok) nxt_state = ST_SLEEP;   // EXIT_DSLP
            end
            default: nxt_state = ST_RUN;
        endcase
    end
endmodule

// File: rtl/lp_out_decode.sv
module lp_out_decode
    import lp_pkg::*;
(
    input  lp_state_e cur_state,
    output lp_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '{core_clk_en: 1'b1, pll_en: 1'b1, evt_mask: 1'b0};
        unique case (cur_state)
            ST_RUN, ST_SG: ctrl = '{core_clk_en: 1'b1, pll_en: 1'b1, evt_mask: 1'b0};
            ST_SLEEP:      ctrl = '{core_clk_en: 1'b0, pll_en: 1'b1, evt_mask: 1'b1};
            ST_DEEP:       ctrl = '{core_clk_en: 1'b0, pll_en: 1'b0, evt_mask: 1'b1};
            default:       ctrl = '{core_clk_en: 1'b1, pll_en: 1'b1, evt_mask: 1'b0};
        endcase
    end
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
    import lp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sg_req,
    input  logic               slp_req,
    input  logic               dslp_req,
    input  logic               bclk_ok,
    output logic [STATE_W-1:0] state_o,
    output logic               core_clk_en,
    output logic               pll_en,
    output logic               evt_mask
);
    lp_state_e state_q;
    lp_state_e state_d;
    lp_ctrl_t  ctrl;

    lp_next_state u_next (
        .cur_state (state_q),
        .sg_req    (sg_req),
        .slp_req   (slp_req),
        .dslp_req  (dslp_req),
        .bclk_ok   (bclk_ok),
        .nxt_state (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    lp_out_decode u_dec (
        .cur_state (state_q),
        .ctrl      (ctrl)
    );

    always_comb begin
        state_o     = state_q;
        core_clk_en = ctrl.core_clk_en;
        pll_en      = ctrl.pll_en;
        evt_mask    = ctrl.evt_mask;
    end

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !sg_req) |=> state_q == ST_RUN); // R2
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SG && slp_req) |=> state_q == ST_SLEEP); // R3
    AST_SLEEP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (!core_clk_en && pll_en && evt_mask)); // R4
    AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && (dslp_req || !bclk_ok)) |=> state_q == ST_DEEP); // R6
    AST_DEEP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP) |-> (!core_clk_en && !pll_en && evt_mask)); // R7
    AST_DEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP && !dslp_req && bclk_ok) |=> state_q == ST_SLEEP); // R8
    AST_NO_RUN_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_SLEEP, ST_DEEP}) |=> state_q != ST_RUN); // R9
endmodule

// File: tb/lp_state_ctrl_tb.sv
module lp_state_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sg_req = 1'b0, slp_req = 1'b0, dslp_req = 1'b0, bclk_ok = 1'b1;
    logic [1:0] state_o;
    logic       core_clk_en, pll_en, evt_mask;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    localparam logic [1:0] RUN = 2'd0, SG = 2'd1, SLP = 2'd2, DSLP = 2'd3;

    always #5 clk = ~clk;

    lp_state_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sg_req(sg_req), .slp_req(slp_req),
        .dslp_req(dslp_req), .bclk_ok(bclk_ok), .state_o(state_o),
        .core_clk_en(core_clk_en), .pll_en(pll_en), .evt_mask(evt_mask)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_st(input logic [1:0] st, input string req);
        logic [2:0] exp_o;
        n_cmp++;
        unique case (st)
            RUN, SG: exp_o = 3'b110;
            SLP:     exp_o = 3'b011;
            default: exp_o = 3'b001;
        endcase
        if (state_o !== st || {core_clk_en, pll_en, evt_mask} !== exp_o) begin
            n_bad++;
            $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
                     req, state_o, {core_clk_en, pll_en, evt_mask}, st, exp_o);
        end
    endtask

    task automatic quiet();
        sg_req = 0; slp_req = 0; dslp_req = 0; bclk_ok = 1;
    endtask

    task automatic t_reset();
        quiet();
        rst_n = 0; #1;
        expect_st(RUN, "R1 in reset");
        @(negedge clk); rst_n = 1;
        step();
        expect_st(RUN, "R1 after reset");
    endtask

    task automatic t_run_ignores();
        slp_req = 1; dslp_req = 1; bclk_ok = 0;
        step(); step();
        expect_st(RUN, "R2 run ignores sleep/deep/bclk");
        quiet();
    endtask

    task automatic t_stop_grant();
        sg_req = 1; step();
        expect_st(SG, "R2 enter stop-grant");
        step();
        expect_st(SG, "R3 stop-grant holds");
        sg_req = 0; step();
        expect_st(RUN, "R3 exit stop-grant");
    endtask

    task automatic t_sleep_wake();
        sg_req = 1; step();
        sg_req = 0; slp_req = 1; step();
        expect_st(SLP, "R3 sleep wins over sg release");
        expect_st(SLP, "R4 sleep outputs");
        step();
        expect_st(SLP, "R9 sg_req low ignored in sleep");
        slp_req = 0; step();
        expect_st(SG, "R5 wake to stop-grant");
        step();
        expect_st(RUN, "R3 back to run");
    endtask

    task automatic t_deep();
        sg_req = 1; step();
        slp_req = 1; step();
        expect_st(SLP, "R3 to sleep");
        slp_req = 0; dslp_req = 1; step();
        expect_st(DSLP, "R6 deep wins over sleep release");
        expect_st(DSLP, "R7 deep outputs");
        sg_req = 0; step();
        expect_st(DSLP, "R9 sg_req ignored in deep");
        dslp_req = 0; bclk_ok = 0; step();
        expect_st(DSLP, "R8 stay while bclk absent");
        bclk_ok = 1; dslp_req = 1; step();
        expect_st(DSLP, "R8 stay while deep held");
        dslp_req = 0; sg_req = 1; slp_req = 1; step();
        expect_st(SLP, "R8 exit deep to sleep");
        bclk_ok = 0; step();
        expect_st(DSLP, "R6 bclk loss to deep");
        rst_n = 0; #1;
        expect_st(RUN, "R1 reset from deep");
        quiet();
        @(negedge clk); rst_n = 1;
        step();
        expect_st(RUN, "R1 run after deep reset");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_run_ignores();
        t_stop_grant();
        t_sleep_wake();
        t_deep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule